// File: doc/BRIEF.md
# Daisy-Chain Unit-ID Packet Router

This block makes the routing decision for a node on a daisy-chained packet link with two ports. Every packet opens with a header beat, and the header carries a 5-bit unit ID that names its stream. The node owns a contiguous run of unit IDs, given by a base and a count that are written through a small configuration port. A packet whose ID falls inside that run is steered to the local port. Any other packet goes into a short pass-through queue toward the next link in the chain.

A node can be configured as the chain's last node. On such a node a missed non-posted packet is absorbed, and one error response is raised toward the host in its place. The response echoes the request's tag. A missed posted packet on the last node is discarded without a response and is tallied in a saturating counter. The route is fixed when the header beat is accepted and holds until that packet's last beat. Forwarded beats leave in arrival order, and no other packet's beats are mixed into them.

Top module: `unit_id_router`

## Requirements
- R1: A header with unit ID bits [4:0] = id is local when base <= id < base+count. A configuration write changes the routing from the cycle after the write. A header accepted on the same edge as a write is routed by the old settings.
- R2: Unit ID 0 belongs to the host and is never routed locally, whatever the base and count are.
- R3: When the node is not the end of the chain, a packet that is not local is forwarded. Its beats appear on the forward port in arrival order with sop/eop and data unchanged, and no other packet is interleaved with them.
- R4: The route chosen at a packet's header beat applies to every beat up to and including eop. A configuration write in the middle of a packet has no effect on that packet.
- R5: On an end-of-chain node, a non-posted miss (header bit 5 = 0) is consumed in full and produces exactly one response word. That word copies header bits [15:0], including the tag in [15:8], sets the error bit 6, clears bit 5, and zeroes every bit above 15.
- R6: On an end-of-chain node, a posted miss (header bit 5 = 1) is consumed with no output on any port, and the drop counter rises by one per packet. The counter saturates at its maximum value.
- R7: A pending response holds its valid and data until rsp_ready_i is high. While a response is pending, a header that needs a new response is stalled with in_ready_o low. Headers that need no response still pass.
- R8: The forward queue holds FWD_DEPTH beats. When it is full, a beat routed forward sees in_ready_o low until space frees up.
- R9: Local beats pass through in the same cycle as they arrive, and loc_ready_i gates in_ready_o for them.
- R10: After reset, no output is valid, the drop counter is zero, and the configuration is base 0, count 0, not end-of-chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_base_i | input | 5 | First owned unit ID |
| cfg_count_i | input | 6 | Number of owned unit IDs |
| cfg_end_i | input | 1 | Node is the end of the chain |
| in_valid_i | input | 1 | Incoming beat valid |
| in_ready_o | output | 1 | Incoming beat accepted |
| in_sop_i | input | 1 | Beat is a header |
| in_eop_i | input | 1 | Last beat of packet |
| in_data_i | input | DATA_W | Beat data |
| loc_valid_o | output | 1 | Local beat valid |
| loc_ready_i | input | 1 | Local sink ready |
| loc_sop_o | output | 1 | Local header beat |
| loc_eop_o | output | 1 | Local last beat |
| loc_data_o | output | DATA_W | Local beat data |
| fwd_valid_o | output | 1 | Forward beat valid |
| fwd_ready_i | input | 1 | Next link ready |
| fwd_sop_o | output | 1 | Forward header beat |
| fwd_eop_o | output | 1 | Forward last beat |
| fwd_data_o | output | DATA_W | Forward beat data |
| rsp_valid_o | output | 1 | Error response valid |
| rsp_ready_i | input | 1 | Host path ready |
| rsp_data_o | output | DATA_W | Error response word |
| drop_count_o | output | DROP_W | Dropped posted misses |

## Verification
Two events can land on the same clock edge: a configuration write and the acceptance of a header beat. The same goes for a write that arrives while a packet is in the middle of transfer. The bench provokes the first case by driving a header together with cfg_we_i, so that the old and new settings route the packet to different ports. The result is judged by which port the whole packet comes out on. The bench then sends a second packet with the same ID to confirm that the new settings took effect one cycle later. A write in mid-packet is judged by checking that every remaining beat stays on the port chosen at the header.

// File: rtl/ur_pkg.sv
package ur_pkg;
  localparam int ID_W       = 5;
  localparam int POSTED_BIT = 5;
  localparam int ERR_BIT    = 6;
  localparam int HDR_KEEP_W = 16;

  typedef enum logic [1:0] {
    RT_LOC  = 2'd0,
    RT_FWD  = 2'd1,
    RT_RSP  = 2'd2,
    RT_DROP = 2'd3
  } route_e;
endpackage

// File: rtl/ur_id_match.sv
module ur_id_match #(
  parameter int ID_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [ID_W-1:0] cfg_base_i,
  input  logic [ID_W:0]   cfg_count_i,
  input  logic            cfg_end_i,
  input  logic [ID_W-1:0] id_i,
  output logic            own_o,
  output logic            end_o
);
  logic [ID_W-1:0] base_q;
  logic [ID_W:0]   count_q;
  logic            end_q;
  logic [ID_W:0]   ofs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      count_q <= '0;
      end_q   <= 1'b0;
    end else if (cfg_we_i) begin
      base_q  <= cfg_base_i;
      count_q <= cfg_count_i;
      end_q   <= cfg_end_i;
    end
  end

  assign ofs   = {1'b0, id_i} - {1'b0, base_q};
  assign own_o = (id_i != '0) && (id_i >= base_q) && (ofs < count_q);
  assign end_o = end_q;

  assert_host_id_not_owned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_i == '0) |-> !own_o);
  assert_empty_range_owns_none_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |-> !own_o);
endmodule

// File: rtl/ur_fifo.sv
module ur_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/ur_rsp_slot.sv
module ur_rsp_slot #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] hdr_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0] word;

  always_comb begin
    word = '0;
    word[ur_pkg::HDR_KEEP_W-1:0] = hdr_i[ur_pkg::HDR_KEEP_W-1:0];
    word[ur_pkg::ERR_BIT]        = 1'b1;
    word[ur_pkg::POSTED_BIT]     = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= word;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_rsp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  assert_load_into_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);
  assert_rsp_marked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (data_o[ur_pkg::ERR_BIT] && !data_o[ur_pkg::POSTED_BIT]));
endmodule

// File: rtl/unit_id_router.sv
module unit_id_router #(
  parameter int DATA_W    = 32,
  parameter int FWD_DEPTH = 4,
  parameter int DROP_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [4:0]        cfg_base_i,
  input  logic [5:0]        cfg_count_i,
  input  logic              cfg_end_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              loc_valid_o,
  input  logic              loc_ready_i,
  output logic              loc_sop_o,
  output logic              loc_eop_o,
  output logic [DATA_W-1:0] loc_data_o,
  output logic              fwd_valid_o,
  input  logic              fwd_ready_i,
  output logic              fwd_sop_o,
  output logic              fwd_eop_o,
  output logic [DATA_W-1:0] fwd_data_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [DROP_W-1:0] drop_count_o
);
  import ur_pkg::*;
  localparam int QW = DATA_W + 2;

  logic          own, is_end, acc;
  route_e        hdr_route, cur_route, route_q;
  logic          q_full, q_empty, q_push, q_pop;
  logic [QW-1:0] q_head;
  logic          rsp_load, drop_inc;
  logic [DROP_W-1:0] drop_q;

  ur_id_match #(.ID_W(ID_W)) u_match (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_base_i, .cfg_count_i, .cfg_end_i,
    .id_i (in_data_i[ID_W-1:0]), .own_o(own), .end_o(is_end)
  );

  always_comb begin
    if (own)                           hdr_route = RT_LOC;
    else if (!is_end)                  hdr_route = RT_FWD;
    else if (in_data_i[POSTED_BIT])    hdr_route = RT_DROP;
    else                               hdr_route = RT_RSP;
  end

  assign cur_route = in_sop_i ? hdr_route : route_q;

  always_comb begin
    case (cur_route)
      RT_LOC:  in_ready_o = loc_ready_i;
      RT_FWD:  in_ready_o = !q_full;
      RT_RSP:  in_ready_o = !(in_sop_i && rsp_valid_o);
      default: in_ready_o = 1'b1;
    endcase
  end

  assign acc = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                route_q <= RT_LOC;
    else if (acc && in_sop_i)   route_q <= hdr_route;
  end

  // local path: same-cycle pass-through
  assign loc_valid_o = in_valid_i && (cur_route == RT_LOC);
  assign loc_sop_o   = in_sop_i;
  assign loc_eop_o   = in_eop_i;
  assign loc_data_o  = in_data_i;

  assign q_push = acc && (cur_route == RT_FWD);
  assign q_pop  = fwd_valid_o && fwd_ready_i;

  ur_fifo #(.W(QW), .DEPTH(FWD_DEPTH)) u_fwd_q (
    .clk_i, .rst_ni, .push_i(q_push), .push_data_i({in_sop_i, in_eop_i, in_data_i}),
    .pop_i(q_pop), .head_o(q_head), .full_o(q_full), .empty_o(q_empty)
  );

  assign fwd_valid_o = !q_empty;
  assign fwd_sop_o   = q_head[QW-1];
  assign fwd_eop_o   = q_head[QW-2];
  assign fwd_data_o  = q_head[DATA_W-1:0];

  assign rsp_load = acc && in_sop_i && (cur_route == RT_RSP);

  ur_rsp_slot #(.W(DATA_W)) u_rsp (
    .clk_i, .rst_ni, .load_i(rsp_load), .hdr_i(in_data_i),
    .ready_i(rsp_ready_i), .valid_o(rsp_valid_o), .data_o(rsp_data_o)
  );

  assign drop_inc = acc && in_sop_i && (cur_route == RT_DROP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        drop_q <= '0;
    else if (drop_inc && drop_q != '1)  drop_q <= drop_q + 1'b1;
  end
  assign drop_count_o = drop_q;

  assert_drop_monotone_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drop_q >= $past(drop_q)));
  assert_drop_seen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_inc |=> (drop_q != '0));
  assert_single_sink_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({q_push, rsp_load, drop_inc, acc && loc_valid_o}) <= 1);
endmodule

// File: tb/unit_id_router_tb_top.sv
module unit_id_router_tb_top;
  localparam int W = 32;
  localparam int DEPTH = 4;
  localparam int DW = 3;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_we = 0, cfg_end = 0;
  logic [4:0] cfg_base = 0;
  logic [5:0] cfg_count = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [W-1:0] in_data = 0;
  logic in_ready;
  logic loc_valid, loc_sop, loc_eop, fwd_valid, fwd_sop, fwd_eop, rsp_valid;
  logic [W-1:0] loc_data, fwd_data, rsp_data;
  logic loc_ready = 1, fwd_ready = 1, rsp_ready = 1;
  logic [DW-1:0] drop_cnt;

  unit_id_router #(.DATA_W(W), .FWD_DEPTH(DEPTH), .DROP_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_base_i(cfg_base),
    .cfg_count_i(cfg_count), .cfg_end_i(cfg_end),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sop_i(in_sop),
    .in_eop_i(in_eop), .in_data_i(in_data),
    .loc_valid_o(loc_valid), .loc_ready_i(loc_ready), .loc_sop_o(loc_sop),
    .loc_eop_o(loc_eop), .loc_data_o(loc_data),
    .fwd_valid_o(fwd_valid), .fwd_ready_i(fwd_ready), .fwd_sop_o(fwd_sop),
    .fwd_eop_o(fwd_eop), .fwd_data_o(fwd_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .drop_count_o(drop_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit rand_rdy = 0;

  int m_base = 0, m_count = 0;
  bit m_end = 0;
  int m_drop = 0;

  logic [W+1:0] exp_loc[$], got_loc[$], exp_fwd[$], got_fwd[$];
  logic [W-1:0] exp_rsp[$], got_rsp[$];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 R2: ownership model
  function automatic bit m_own(int id);
    return (id != 0) && (id >= m_base) && (id - m_base < m_count);
  endfunction

  function automatic logic [W-1:0] m_rsp(logic [W-1:0] h);
    logic [W-1:0] r = '0;
    r[15:0] = h[15:0];
    r[6] = 1'b1;
    r[5] = 1'b0;
    return r;
  endfunction

  // monitor: sample just before the coming edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (loc_valid && loc_ready) got_loc.push_back({loc_sop, loc_eop, loc_data});
        if (fwd_valid && fwd_ready) got_fwd.push_back({fwd_sop, fwd_eop, fwd_data});
        if (rsp_valid && rsp_ready) got_rsp.push_back(rsp_data);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rand_rdy) begin
        loc_ready = ($urandom % 4) != 0;
        fwd_ready = ($urandom % 4) != 0;
        rsp_ready = ($urandom % 3) != 0;
      end
    end
  end

  task automatic set_cfg(int b, int c, bit e);
    @(negedge clk);
    cfg_we = 1; cfg_base = 5'(b); cfg_count = 6'(c); cfg_end = e;
    @(negedge clk);
    cfg_we = 0;
    m_base = b; m_count = c; m_end = e;
  endtask

  task automatic try_beat(bit s, bit e, logic [W-1:0] d, output bit acc);
    @(negedge clk);
    in_valid = 1; in_sop = s; in_eop = e; in_data = d;
    #1;
    acc = in_ready;
    @(posedge clk);
  endtask

  task automatic send_beat(bit s, bit e, logic [W-1:0] d);
    bit a;
    do try_beat(s, e, d, a); while (!a);
  endtask

  // cfg_beat: beat index during which a config write is issued (-1 none)
  task automatic send_pkt(int id, bit posted, int tag, int len,
                          int cfg_beat = -1, int nb = 0, int nc = 0, bit ne = 0);
    logic [W-1:0] h;
    int rt;
    h = $urandom;
    h[4:0] = 5'(id); h[5] = posted; h[15:8] = 8'(tag);
    if (m_own(id)) rt = 0;
    else if (!m_end) rt = 1;
    else if (posted) rt = 3;
    else rt = 2;
    for (int i = 0; i < len; i++) begin
      logic [W-1:0] d = (i == 0) ? h : W'($urandom);
      bit s = (i == 0), e = (i == len - 1);
      if (rt == 0) exp_loc.push_back({s, e, d});
      if (rt == 1) exp_fwd.push_back({s, e, d});
      if (i == cfg_beat) begin
        @(negedge clk);
        cfg_we = 1; cfg_base = 5'(nb); cfg_count = 6'(nc); cfg_end = ne;
        in_valid = 1; in_sop = s; in_eop = e; in_data = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0;
        m_base = nb; m_count = nc; m_end = ne;
        in_valid = 0;
      end else begin
        send_beat(s, e, d);
      end
    end
    if (rt == 2) exp_rsp.push_back(m_rsp(h));
    if (rt == 3 && m_drop < DMAX) m_drop++;
  endtask

  task automatic drain_and_compare(string tag);
    @(negedge clk);
    in_valid = 0;
    rand_rdy = 0;
    loc_ready = 1; fwd_ready = 1; rsp_ready = 1;
    repeat (20) @(negedge clk);
    chk(got_loc.size() == exp_loc.size(), {tag, " R9 local count"}, got_loc.size(), exp_loc.size());
    chk(got_fwd.size() == exp_fwd.size(), {tag, " R3 forward count"}, got_fwd.size(), exp_fwd.size());
    chk(got_rsp.size() == exp_rsp.size(), {tag, " R5 response count"}, got_rsp.size(), exp_rsp.size());
    while (exp_loc.size() > 0 && got_loc.size() > 0) begin
      logic [W+1:0] a = got_loc.pop_front(), x = exp_loc.pop_front();
      chk(a == x, {tag, " R1 local beat"}, 64'(a), 64'(x));
    end
    while (exp_fwd.size() > 0 && got_fwd.size() > 0) begin
      logic [W+1:0] a = got_fwd.pop_front(), x = exp_fwd.pop_front();
      chk(a == x, {tag, " R3 forward beat order"}, 64'(a), 64'(x));
    end
    while (exp_rsp.size() > 0 && got_rsp.size() > 0) begin
      logic [W-1:0] a = got_rsp.pop_front(), x = exp_rsp.pop_front();
      chk(a == x, {tag, " R5 response word"}, 64'(a), 64'(x));
    end
    chk(int'(drop_cnt) == m_drop, {tag, " R6 drop count"}, 64'(drop_cnt), 64'(m_drop));
    exp_loc.delete(); got_loc.delete(); exp_fwd.delete();
    got_fwd.delete(); exp_rsp.delete(); got_rsp.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R10 reset state
    chk(!fwd_valid, "R10 fwd_valid after reset", fwd_valid, 0);
    chk(!rsp_valid, "R10 rsp_valid after reset", rsp_valid, 0);
    chk(!loc_valid, "R10 loc_valid after reset", loc_valid, 0);
    chk(drop_cnt == 0, "R10 drop count after reset", drop_cnt, 0);
    // R10: default config owns nothing -> id 5 forwarded
    send_pkt(5, 0, 8'h11, 2);
    drain_and_compare("R10 default");

    // R1 range edges, R3 forwarding, R9
    set_cfg(4, 3, 0);
    send_pkt(3, 0, 1, 1); send_pkt(4, 0, 2, 3); send_pkt(6, 1, 3, 2);
    send_pkt(7, 0, 4, 2); send_pkt(31, 0, 5, 4);
    drain_and_compare("R1 edges");

    // R2 host ID never local
    set_cfg(0, 4, 0);
    send_pkt(0, 0, 6, 2); send_pkt(1, 0, 7, 1); send_pkt(3, 1, 8, 1); send_pkt(4, 0, 9, 1);
    drain_and_compare("R2 host id");

    // R1 top of ID space
    set_cfg(28, 8, 0);
    send_pkt(28, 0, 10, 1); send_pkt(31, 0, 11, 2); send_pkt(2, 0, 12, 1); send_pkt(27, 0, 13, 1);
    drain_and_compare("R1 top");

    // R5 R6 end of chain
    set_cfg(8, 2, 1);
    send_pkt(12, 0, 8'hA5, 3); send_pkt(13, 1, 8'h5A, 2); send_pkt(9, 0, 14, 2);
    send_pkt(0, 0, 8'h3C, 1);
    drain_and_compare("R5 R6 end");

    // R7 response back-pressure
    @(negedge clk);
    rsp_ready = 0;
    send_pkt(20, 0, 8'h21, 1);
    try_beat(1, 1, W'(32'h0000_2215), a);
    chk(!a, "R7 second miss header stalled", a, 0);
    send_pkt(8, 0, 8'h23, 2);
    @(negedge clk);
    in_valid = 0;
    chk(rsp_valid, "R7 response still held", rsp_valid, 1);
    rsp_ready = 1;
    send_pkt(21, 0, 8'h22, 1);
    drain_and_compare("R7 hold");

    // R8 forward queue full
    set_cfg(8, 2, 0);
    @(negedge clk);
    fwd_ready = 0;
    for (int i = 0; i < DEPTH; i++) send_pkt(16 + i, 0, i, 1);
    try_beat(1, 1, W'(32'h0000_0019), a);
    chk(!a, "R8 beat stalled on full queue", a, 0);
    @(negedge clk);
    in_valid = 0;
    drain_and_compare("R8 full");

    // R1 same-edge config write with header: old settings route it
    set_cfg(4, 2, 0);
    send_pkt(10, 0, 8'h44, 3, 0, 8, 4, 0);
    send_pkt(10, 0, 8'h45, 2);
    drain_and_compare("R1 same edge");

    // R4 mid-packet config write
    send_pkt(9, 0, 8'h46, 4, 2, 16, 2, 1);
    send_pkt(9, 0, 8'h47, 1);
    drain_and_compare("R4 mid packet");

    // R6 saturation
    set_cfg(1, 1, 1);
    for (int i = 0; i < 9; i++) send_pkt(30, 1, i, 1);
    drain_and_compare("R6 saturate");

    // random mix, all requirements
    for (int r = 0; r < 12; r++) begin
      set_cfg($urandom % 32, $urandom % 12, ($urandom % 3) == 0);
      @(negedge clk);
      rand_rdy = 1;
      for (int p = 0; p < 25; p++)
        send_pkt($urandom % 32, $urandom % 2, $urandom % 256, 1 + $urandom % 4);
      drain_and_compare("random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule